// File: doc/BRIEF.md
# Shift-Amount Register Shifter

This block is the shift unit of a small integer pipeline. It keeps a 6-bit shift-amount register (SAR) of its own, loaded by a family of "set amount" operations, and performs 32-bit logical-right, arithmetic-right, left and funnel right shifts whose distance is taken from that register. A second family of operations takes its distance from a 5-bit immediate and never looks at the SAR. A field-extract operation and direct write, read and swap access to the SAR complete the set.

Each operation enters on a valid/ready handshake together with two operands (`in_a`, `in_b`), an immediate and a field width. An accepted operation updates the SAR at the accepting clock edge and places its result into a one-entry output register. A result is held, unchanged, until the consumer takes it with `out_ready`. A new operation is accepted only when that register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). Back-pressure therefore stalls the input, and a stalled operation does not touch the SAR. An operation always reads the SAR value as it stood before the edge that accepts it, so a shift may directly follow the set that feeds it.

Top module: `sar_shifter`

## Requirements
- R1: While `rst_n` is low and after its release, `sar_rd` reads 0 and `out_valid` is 0.
- R2: Opcode 0 sets the SAR to `in_a[4:0]`. Opcode 1 sets it to 32 minus `in_a[4:0]`, so an amount of 0 loads 32.
- R3: Opcode 2 sets the SAR to `(in_a*8)` masked to 5 bits. Opcode 3 sets it to 32 minus that masked value.
- R4: Opcode 4 loads the SAR with `in_imm`. Opcode 5 writes `in_a[5:0]`. Opcode 6 writes `in_a[5:0]` and returns the previous SAR as its result. Opcodes 0 to 5 return 0 as their result.
- R5: Opcode 8 returns `in_b` shifted logically right by SAR, and opcode 9 returns it shifted arithmetically right by SAR. The shift is done as a 64-bit operation, so a SAR of 32 or more gives all zeros (opcode 8) or all copies of bit 31 (opcode 9).
- R6: Opcode 10 returns the low 32 bits of the zero-extended `in_b` shifted left by `(32 - SAR) mod 64`. A SAR of 0 or one above 32 gives 0.
- R7: Opcode 11 returns the low 32 bits of the 64-bit value `{in_a, in_b}` shifted right by SAR.
- R8: Opcode 12 shifts `in_b` left by `32 - in_imm`, so an immediate of 0 gives 0. Opcode 13 shifts it arithmetically right by `in_imm`. Opcode 14 shifts it logically right by `in_imm[3:0]` only. None of these reads or changes the SAR.
- R9: Opcode 15 returns `(in_b >> in_imm)` masked to its low `in_fw+1` bits (a field of 1 to 16 bits).
- R10: The result of an operation accepted at edge k is valid after edge k. It is held stable while `out_ready` is low. `in_ready` equals `!out_valid || out_ready`. An operation that is not accepted leaves the SAR unchanged.
- R11: Opcode 7 returns the current SAR zero-extended to 32 bits, and `sar_rd` always shows the SAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | First operand (set-amount source, funnel high word) |
| in_b | input | 32 | Second operand (shifted value, funnel low word) |
| in_imm | input | 5 | Immediate shift amount or SAR constant |
| in_fw | input | 4 | Extract field width minus one |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result |
| sar_rd | output | 6 | Current shift-amount register |

## Verification
Every result is due exactly one clock edge after the edge that accepts its operation, and the SAR written by that operation is visible on `sar_rd` after the same edge. The reference model advances once per clock on the handshake it predicts itself and compares `in_ready`, `out_valid`, `out_data` and `sar_rd` a little after every rising edge, so a result that arrives a cycle early or late fails. Back-pressure runs hold a result across stalled cycles and present set operations that must not be accepted. Directed cases cover SAR values 0, 32 and above 32, the immediate 0 for the left shift, the truncated immediate of the logical right shift and the widest and narrowest extract fields.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [3:0] {
    OP_SAR_RIGHT   = 4'd0,
    OP_SAR_LEFT    = 4'd1,
    OP_SAR_BYTE_LE = 4'd2,
    OP_SAR_BYTE_BE = 4'd3,
    OP_SAR_IMM     = 4'd4,
    OP_SAR_WRITE   = 4'd5,
    OP_SAR_SWAP    = 4'd6,
    OP_SAR_READ    = 4'd7,
    OP_SHR_L       = 4'd8,
    OP_SHR_A       = 4'd9,
    OP_SHL         = 4'd10,
    OP_FUNNEL      = 4'd11,
    OP_SHLI        = 4'd12,
    OP_SHRAI       = 4'd13,
    OP_SHRLI       = 4'd14,
    OP_EXTRACT     = 4'd15
  } sar_op_e;
endpackage

// File: rtl/sar_amount_reg.sv
module sar_amount_reg
  import sar_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = $clog2(DW),
  parameter int SAW = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  sar_op_e        op,
  input  logic [SAW-1:0] a_lo,
  input  logic [AW-1:0]  imm,
  output logic [SAW-1:0] sar_q
);
  localparam logic [SAW-1:0] FULL = SAW'(DW);

  logic [AW-1:0]  byte_amt;
  logic [SAW-1:0] sar_d;

  // byte count to bit count, wrapped to the word width
  assign byte_amt = {a_lo[AW-4:0], 3'b000};

  always_comb begin
    sar_d = sar_q;
    case (op)
      OP_SAR_RIGHT:   sar_d = {1'b0, a_lo[AW-1:0]};
      OP_SAR_LEFT:    sar_d = FULL - {1'b0, a_lo[AW-1:0]};
      OP_SAR_BYTE_LE: sar_d = {1'b0, byte_amt};
      OP_SAR_BYTE_BE: sar_d = FULL - {1'b0, byte_amt};
      OP_SAR_IMM:     sar_d = {1'b0, imm};
      OP_SAR_WRITE,
      OP_SAR_SWAP:    sar_d = a_lo;
      default:        sar_d = sar_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sar_q <= '0;
    else if (load) sar_q <= sar_d;
  end
endmodule

// File: rtl/sar_shift_core.sv
module sar_shift_core
  import sar_pkg::*;
#(
  parameter int DW  = 32,
  parameter int FW  = 16,
  parameter int AW  = $clog2(DW),
  parameter int SAW = AW + 1,
  parameter int FWB = $clog2(FW)
) (
  input  sar_op_e        op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [AW-1:0]  imm,
  input  logic [FWB-1:0] fw,
  input  logic [SAW-1:0] sar,
  output logic [DW-1:0]  res
);
  localparam logic [SAW-1:0] FULL = SAW'(DW);
  localparam int NIB = AW - 1;

  logic [SAW-1:0] reg_left_amt;
  logic [SAW-1:0] imm_left_amt;
  logic [DW-1:0]  field_mask;
  logic signed [DW-1:0] b_s;

  assign reg_left_amt = FULL - sar;
  assign imm_left_amt = FULL - {1'b0, imm};
  assign b_s = b;

  // field mask: bit i set when i <= fw
  for (genvar i = 0; i < DW; i++) begin : g_mask
    if (i < FW) begin : g_in
      assign field_mask[i] = ({1'b0, fw} >= (FWB+1)'(i));
    end else begin : g_out
      assign field_mask[i] = 1'b0;
    end
  end

  always_comb begin
    res = '0;
    case (op)
      OP_SHR_L:    res = DW'({{DW{1'b0}}, b} >> sar);
      OP_SHR_A:    res = DW'($signed({{DW{b[DW-1]}}, b}) >>> sar);
      OP_SHL:      res = DW'({{DW{1'b0}}, b} << reg_left_amt);
      OP_FUNNEL:   res = DW'({a, b} >> sar);
      OP_SHLI:     res = DW'({{DW{1'b0}}, b} << imm_left_amt);
      OP_SHRAI:    res = b_s >>> imm;
      OP_SHRLI:    res = b >> imm[NIB-1:0];
      OP_EXTRACT:  res = (b >> imm) & field_mask;
      OP_SAR_READ,
      OP_SAR_SWAP: res = DW'(sar);
      default:     res = '0;
    endcase
  end
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/sar_shifter.sv
module sar_shifter
  import sar_pkg::*;
#(
  parameter int DW  = 32,
  parameter int FW  = 16,
  parameter int AW  = $clog2(DW),
  parameter int SAW = AW + 1,
  parameter int FWB = $clog2(FW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [3:0]     in_op,
  input  logic [DW-1:0]  in_a,
  input  logic [DW-1:0]  in_b,
  input  logic [AW-1:0]  in_imm,
  input  logic [FWB-1:0] in_fw,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic [SAW-1:0] sar_rd
);
  sar_op_e        op;
  logic           take;
  logic [DW-1:0]  result;

  assign op   = sar_op_e'(in_op);
  assign take = in_valid && in_ready;

  sar_amount_reg #(.DW(DW), .AW(AW), .SAW(SAW)) u_sar (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take),
    .op    (op),
    .a_lo  (in_a[SAW-1:0]),
    .imm   (in_imm),
    .sar_q (sar_rd)
  );

  sar_shift_core #(.DW(DW), .FW(FW), .AW(AW), .SAW(SAW), .FWB(FWB)) u_core (
    .op  (op),
    .a   (in_a),
    .b   (in_b),
    .imm (in_imm),
    .fw  (in_fw),
    .sar (sar_rd),
    .res (result)
  );

  sar_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (result),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/sar_shifter_chk.sv
module sar_shifter_chk
  import sar_pkg::*;
#(
  parameter int DW  = 32,
  parameter int FW  = 16,
  parameter int AW  = $clog2(DW),
  parameter int SAW = AW + 1,
  parameter int FWB = $clog2(FW)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [3:0]     in_op,
  input logic [DW-1:0]  in_a,
  input logic [DW-1:0]  in_b,
  input logic [AW-1:0]  in_imm,
  input logic [FWB-1:0] in_fw,
  input logic           out_valid,
  input logic           out_ready,
  input logic [DW-1:0]  out_data,
  input logic [SAW-1:0] sar_rd
);
  logic take;
  assign take = in_valid && in_ready;

  always_comb begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (sar_rd == '0 && !out_valid);
    end
  end

  p_set_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_SAR_RIGHT |=> sar_rd == {1'b0, $past(in_a[AW-1:0])});

  p_set_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_SAR_LEFT |=> sar_rd == SAW'(DW) - {1'b0, $past(in_a[AW-1:0])});

  p_write_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_SAR_WRITE |=> sar_rd == $past(in_a[SAW-1:0]));

  p_swap_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_SAR_SWAP |=> out_data == DW'($past(sar_rd)));

  p_srl_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_SHR_L && sar_rd >= SAW'(DW) |=> out_data == '0);

  p_sll_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_SHL && sar_rd == '0 |=> out_data == '0);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_stall_sar_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(sar_rd));

  p_ready_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind sar_shifter sar_shifter_chk #(.DW(DW), .FW(FW), .AW(AW), .SAW(SAW), .FWB(FWB)) u_chk (.*);

// File: tb/test_sar_shifter.sv
module test_sar_shifter;
  import sar_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [4:0]  in_imm = '0;
  logic [3:0]  in_fw = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [5:0]  sar_rd;

  int checks = 0;
  int failures = 0;

  // model state
  bit          m_valid = 1'b0;
  logic [31:0] m_data = '0;
  int          m_sar = 0;
  string       m_tag = "R1";

  always #2 clk = ~clk;

  sar_shifter i_sar_shifter (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5, 4'd6: return "R4";
      4'd7: return "R11";
      4'd8, 4'd9: return "R5";
      4'd10: return "R6";
      4'd11: return "R7";
      4'd12, 4'd13, 4'd14: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] ref_res(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                          int imm, int fw, int s);
    logic [63:0] w;
    int amt;
    case (op)
      4'd6, 4'd7: return 32'(s);
      4'd8:  return (s >= 32) ? 32'd0 : b >> s;
      4'd9:  return (s >= 32) ? {32{b[31]}} : 32'($signed(b) >>> s);
      4'd10: begin amt = (32 - s) & 63; return (amt >= 32) ? 32'd0 : b << amt; end
      4'd11: begin w = {a, b}; w = w >> s; return w[31:0]; end
      4'd12: begin amt = 32 - imm; return (amt >= 32) ? 32'd0 : b << amt; end
      4'd13: return 32'($signed(b) >>> imm);
      4'd14: return b >> (imm % 16);
      4'd15: return (b >> imm) & ((32'd1 << (fw + 1)) - 32'd1);
      default: return 32'd0;
    endcase
  endfunction

  function automatic int ref_sar(logic [3:0] op, logic [31:0] a, int imm, int s);
    case (op)
      4'd0: return int'(a[4:0]);
      4'd1: return 32 - int'(a[4:0]);
      4'd2: return (int'(a[4:0]) * 8) % 32;
      4'd3: return 32 - ((int'(a[4:0]) * 8) % 32);
      4'd4: return imm;
      4'd5, 4'd6: return int'(a[5:0]);
      default: return s;
    endcase
  endfunction

  // one clock: inputs already driven at the falling edge
  task automatic cyc();
    bit exp_ready;
    bit take;
    logic [31:0] nr;
    int ns;
    #1;
    exp_ready = !m_valid || out_ready;
    check("R10", 32'(in_ready), 32'(exp_ready));
    take = in_valid && exp_ready;
    nr = ref_res(in_op, in_a, in_b, int'(in_imm), int'(in_fw), m_sar);
    ns = ref_sar(in_op, in_a, int'(in_imm), m_sar);
    @(posedge clk);
    #1;
    if (take) begin
      m_valid = 1'b1;
      m_data  = nr;
      m_sar   = ns;
      m_tag   = req_of(in_op);
    end else if (out_ready) begin
      m_valid = 1'b0;
    end
    check("R10", 32'(out_valid), 32'(m_valid));
    if (m_valid) check(m_tag, out_data, m_data);
    check(take ? m_tag : "R10", 32'(sar_rd), 32'(m_sar));
    @(negedge clk);
  endtask

  task automatic issue(logic [3:0] op, logic [31:0] a, logic [31:0] b, int imm, int fw);
    in_valid = 1'b1;
    in_op    = op;
    in_a     = a;
    in_b     = b;
    in_imm   = 5'(imm);
    in_fw    = 4'(fw);
    cyc();
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'(sar_rd), 32'd0);
    check("R1", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(sar_rd), 32'd0);
    check("R1", 32'(out_valid), 32'd0);

    issue(OP_SAR_RIGHT, 32'h25, 0, 0, 0);              // R2: sar 5
    issue(OP_SHR_L, 0, 32'h8000_0000, 0, 0);           // R5
    issue(OP_SHR_A, 0, 32'h8000_0000, 0, 0);           // R5
    issue(OP_SAR_LEFT, 32'h0, 0, 0, 0);                // R2: sar 32
    issue(OP_SHL, 0, 32'hDEAD_BEEF, 0, 0);             // R6: amount 0
    issue(OP_SHR_L, 0, 32'hFFFF_FFFF, 0, 0);           // R5: 32 -> 0
    issue(OP_SHR_A, 0, 32'h8000_0001, 0, 0);           // R5: sign fill
    issue(OP_SAR_LEFT, 32'h8, 0, 0, 0);                // R2: sar 24
    issue(OP_SHL, 0, 32'h1, 0, 0);                     // R6: << 8
    issue(OP_SAR_BYTE_LE, 32'h3, 0, 0, 0);             // R3: sar 24
    issue(OP_FUNNEL, 32'h1122_3344, 32'h5566_7788, 0, 0); // R7
    issue(OP_SAR_BYTE_BE, 32'h5, 0, 0, 0);             // R3: 32-8
    issue(OP_FUNNEL, 32'hCAFE_F00D, 32'h1234_5678, 0, 0); // R7
    issue(OP_SAR_IMM, 0, 0, 17, 0);                    // R4
    issue(OP_SAR_WRITE, 32'hFFFF_FFFA, 0, 0, 0);       // R4: keeps 58
    issue(OP_SHR_L, 0, 32'hFFFF_FFFF, 0, 0);           // R5
    issue(OP_SHL, 0, 32'hFFFF_FFFF, 0, 0);             // R6: amount 38
    issue(OP_SHR_A, 0, 32'h9000_0000, 0, 0);           // R5
    issue(OP_SAR_SWAP, 32'h9, 0, 0, 0);                // R4: returns 58
    issue(OP_SAR_READ, 0, 0, 0, 0);                    // R11
    issue(OP_SAR_RIGHT, 32'h0, 0, 0, 0);               // R2: sar 0
    issue(OP_SHL, 0, 32'hFFFF_FFFF, 0, 0);             // R6: sar 0 -> 0
    issue(OP_FUNNEL, 32'hAAAA_AAAA, 32'h5555_5555, 0, 0); // R7: sar 0
    issue(OP_SHLI, 0, 32'hFFFF_FFFF, 0, 0);            // R8: imm 0 -> 0
    issue(OP_SHLI, 0, 32'h0000_000F, 4, 0);            // R8
    issue(OP_SHRAI, 0, 32'h8000_0000, 31, 0);          // R8
    issue(OP_SHRLI, 0, 32'hF000_0000, 20, 0);          // R8: only 4
    issue(OP_SAR_READ, 0, 0, 0, 0);                    // R8: sar untouched
    issue(OP_EXTRACT, 0, 32'hABCD_1234, 8, 3);         // R9
    issue(OP_EXTRACT, 0, 32'hABCD_1234, 8, 15);        // R9
    issue(OP_EXTRACT, 0, 32'hFFFF_FFFF, 31, 0);        // R9

    // R10: back-pressure holds the result and a stalled set is ignored
    out_ready = 1'b0;
    issue(OP_SAR_SWAP, 32'h21, 0, 0, 0);
    in_valid = 1'b1; in_op = OP_SAR_RIGHT; in_a = 32'h7;
    cyc(); cyc(); cyc();
    out_ready = 1'b1;
    cyc();
    in_valid = 1'b0;
    cyc(); cyc();

    // R10: mixed traffic with random stalls
    for (int n = 0; n < 400; n++) begin
      out_ready = ($urandom_range(0, 3) != 0);
      in_valid  = ($urandom_range(0, 4) != 0);
      in_op     = 4'($urandom_range(0, 15));
      in_a      = $urandom;
      in_b      = $urandom;
      in_imm    = 5'($urandom_range(0, 31));
      in_fw     = 4'($urandom_range(0, 15));
      cyc();
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    cyc(); cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule